// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves bytes between a processor and a serial link that runs on a shift clock the block generates itself. A byte written into the transmit holding register is copied into a shift register and sent out on `txd`, least significant bit first. At the same time, the byte arriving on `rxd` is assembled and placed in a receive holding register. Transmit and receive can each be enabled on their own or together. In full duplex both directions share one shift clock.

Software sees three flags: transmit-empty, receive-full and overrun. Each flag raises a one-cycle request when it goes from 0 to 1. A second access port lets a transfer engine write the transmit holding register or read the receive holding register. Such an access clears the matching flag by itself, so the engine never touches the status register.

Each frame has a hard deadline at its final data bit. A byte committed before the current frame ends is sent with no idle gap. A received byte still unread when the final bit of the next frame is sampled causes an overrun. Reception then halts until software writes the overrun flag back to 0.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `sclk` and `txd` are 1, transmit-empty is 1, receive-full and overrun are 0, both enables are 0, and all three request outputs are 0.
- R2: A frame is DATA_W bits, least significant bit first. `txd` changes only in the cycle in which `sclk` falls. `rxd` is sampled at the edge that raises `sclk`. Each half of the shift clock lasts DIV_HALF cycles, and a frame starts with a falling edge.
- R3: Register map on `regSel`, read combinationally on `regRdata`:
  - 0 is control: bit 0 enables transmit, bit 1 enables receive.
  - 1 is status: bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun. Writing 0 to a status bit clears it. Writing 1 has no effect.
  - 2 is the transmit holding register, read/write.
  - 3 is the receive holding register, read only. A write to it is ignored.
- R4: Writing the transmit holding register alone starts nothing. With transmit enabled, clearing transmit-empty commits the byte. The next clock edge then starts a frame, copies the byte into the shift register and sets transmit-empty back to 1.
- R5: `txIrq` is high for exactly the first cycle in which transmit-empty reads 1 after reading 0.
- R6: At the edge that samples the final bit, if receive-full is 0, the byte is stored in the receive holding register and receive-full is set. `rxIrq` pulses for one cycle on that 0-to-1 transition.
- R7: If receive-full is still 1 when the final bit is sampled, overrun is set and `ovrIrq` pulses. The receive holding register keeps its earlier byte and the new byte is lost.
- R8: A frame that starts while overrun is 1 receives nothing. In receive-only mode the clock stops once overrun is set. Reception resumes after software writes overrun to 0.
- R9: A byte committed before the current frame ends follows that frame with no idle cycle on `sclk`.
- R10: With transmit enabled and transmit-empty still 1 at the end of a frame, `sclk` stops high and `txd` holds the last bit sent.
- R11: A write on the agent port loads the transmit holding register and clears transmit-empty. A read strobe on the agent port clears receive-full. Processor reads change no flag.
- R12: With only receive enabled and overrun 0, frames follow one another with no idle cycle. This holds even while receive-full is 1.
- R13: Enables are captured when a frame starts, and a frame in progress always completes. With both enabled, one frame sends a byte and receives a byte on the same shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| regSel | input | 2 | Register select (see R3) |
| regWr | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for `regSel` |
| agentTxWr | input | 1 | Agent write to the transmit holding register |
| agentTxData | input | DATA_W | Agent transmit byte |
| agentRxRd | input | 1 | Agent read strobe for the receive holding register |
| agentRxData | output | DATA_W | Receive holding register contents |
| txIrq | output | 1 | Transmit-empty rise request |
| rxIrq | output | 1 | Receive-full rise request |
| ovrIrq | output | 1 | Overrun rise request |
| sclk | output | 1 | Shift clock, idle high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The bench builds the block with DATA_W = 8 and DIV_HALF = 2, so a frame takes 32 cycles. At that length the final-bit deadlines can be hit from several directions within a few dozen cycles: back-to-back sends, overrun after one unread frame, and a flag cleared on the same edge as a final-bit sample. The short half period also means a long random phase covers mode changes in the middle of a frame. A loopback path from `txd` to `rxd` checks full duplex, and a pattern source driven from `sclk` checks receive-only mode.

// File: rtl/csx_pkg.sv
package csx_pkg;

  // register select codes
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_TXH  = 2'd2;
  localparam logic [1:0] SEL_RXH  = 2'd3;

  // status bit positions
  localparam int FLAG_TXE = 0;
  localparam int FLAG_RXF = 1;
  localparam int FLAG_OVR = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // copy holding register into shifter, drive bit 0
    logic shiftTx;   // advance to next transmit bit
    logic sampleRx;  // capture rxd into receive shifter
    logic xferRx;    // move completed byte into receive holding register
    logic writeTxh;  // update transmit holding register
    logic pickAgent; // holding register data comes from agent port
  } csx_strobe_t;

endpackage

// File: rtl/csx_ctrl.sv
module csx_ctrl
  import csx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic [2:0]  wrBits,
  input  logic        agentTxWr,
  input  logic        agentRxRd,
  output csx_strobe_t strobe,
  output logic        sclk,
  output logic        txEn,
  output logic        rxEn,
  output logic        txEmpty,
  output logic        rxFull,
  output logic        overrun,
  output logic        txIrq,
  output logic        rxIrq,
  output logic        ovrIrq
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_HALF - 1);

  logic             active;
  logic             phaseHigh;
  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             txOn, rxOn;
  logic             txEmptyPrev, rxFullPrev, overrunPrev;

  logic tick, riseEv, fallEv, endEv, lastRise, wantFrame, beginFrame, setOvr;
  logic ctrlWr, statWr, txhWr;

  // decode
  assign ctrlWr = regWr && (regSel == SEL_CTRL);
  assign statWr = regWr && (regSel == SEL_STAT);
  assign txhWr  = regWr && (regSel == SEL_TXH);

  // frame timing
  assign tick       = active && (divCnt == DIV_LAST);
  assign riseEv     = tick && !phaseHigh;
  assign lastRise   = riseEv && (bitIdx == LAST_BIT);
  assign fallEv     = tick && phaseHigh && (bitIdx != LAST_BIT);
  assign endEv      = tick && phaseHigh && (bitIdx == LAST_BIT);
  assign wantFrame  = txEn ? !txEmpty : (rxEn && !overrun);
  assign beginFrame = wantFrame && (!active || endEv);
  assign setOvr     = lastRise && rxOn && rxFull;

  always_comb begin
    strobe           = '0;
    strobe.loadTx    = beginFrame && txEn;
    strobe.shiftTx   = fallEv && txOn;
    strobe.sampleRx  = riseEv && rxOn;
    strobe.xferRx    = lastRise && rxOn && !rxFull;
    strobe.writeTxh  = txhWr || agentTxWr;
    strobe.pickAgent = agentTxWr;
  end

  // sequencer
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      active    <= 1'b0;
      phaseHigh <= 1'b1;
      divCnt    <= '0;
      bitIdx    <= '0;
      sclk      <= 1'b1;
      txOn      <= 1'b0;
      rxOn      <= 1'b0;
    end else if (beginFrame) begin
      active    <= 1'b1;
      phaseHigh <= 1'b0;
      divCnt    <= '0;
      bitIdx    <= '0;
      sclk      <= 1'b0;
      txOn      <= txEn;
      rxOn      <= rxEn && !overrun;
    end else if (active) begin
      if (tick) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
          sclk      <= 1'b1;
        end else if (bitIdx != LAST_BIT) begin
          bitIdx    <= bitIdx + 1'b1;
          phaseHigh <= 1'b0;
          sclk      <= 1'b0;
        end else begin
          active <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // enables and flags
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      txEn        <= 1'b0;
      rxEn        <= 1'b0;
      txEmpty     <= 1'b1;
      rxFull      <= 1'b0;
      overrun     <= 1'b0;
      txEmptyPrev <= 1'b1;
      rxFullPrev  <= 1'b0;
      overrunPrev <= 1'b0;
    end else begin
      if (ctrlWr) begin
        txEn <= wrBits[0];
        rxEn <= wrBits[1];
      end
      if (strobe.loadTx)
        txEmpty <= 1'b1;
      else if ((statWr && !wrBits[FLAG_TXE]) || agentTxWr)
        txEmpty <= 1'b0;
      if (strobe.xferRx)
        rxFull <= 1'b1;
      else if ((statWr && !wrBits[FLAG_RXF]) || agentRxRd)
        rxFull <= 1'b0;
      if (setOvr)
        overrun <= 1'b1;
      else if (statWr && !wrBits[FLAG_OVR])
        overrun <= 1'b0;
      txEmptyPrev <= txEmpty;
      rxFullPrev  <= rxFull;
      overrunPrev <= overrun;
    end
  end

  assign txIrq  = txEmpty && !txEmptyPrev;
  assign rxIrq  = rxFull && !rxFullPrev;
  assign ovrIrq = overrun && !overrunPrev;

  // R10: shift clock rests high whenever no frame is running
  p_sclk_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    !active |-> sclk);

  // R4: transmit-empty only returns to 1 as a frame launches
  p_tx_empty_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(txEmpty) |-> $fell(sclk));

  // R5: transmit request is a single-cycle pulse
  p_tx_irq_once_r5: assert property (@(posedge clk) disable iff (rst)
    txIrq |=> !txIrq);

  // R6: receive request is a single-cycle pulse
  p_rx_irq_once_r6: assert property (@(posedge clk) disable iff (rst)
    rxIrq |=> !rxIrq);

  // R8: no byte is accepted while overrun is pending
  p_no_rx_in_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rxFull) |-> !$past(overrun));

endmodule

// File: rtl/csx_datapath.sv
module csx_datapath
  import csx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  csx_strobe_t       strobe,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [DATA_W-1:0] agentData,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] txHold,
  output logic [DATA_W-1:0] rxHold
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxd, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      txHold <= '0;
    end else if (strobe.writeTxh) begin
      txHold <= strobe.pickAgent ? agentData : cpuData;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      txShift <= '0;
      txd     <= 1'b1;
    end else if (strobe.loadTx) begin
      txShift <= txHold;
      txd     <= txHold[0];
    end else if (strobe.shiftTx) begin
      txShift <= txShift >> 1;
      txd     <= txShift[1];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (strobe.sampleRx)
        rxShift <= rxNext;
      if (strobe.xferRx)
        rxHold <= rxNext;
    end
  end

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import csx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              agentTxWr,
  input  logic [DATA_W-1:0] agentTxData,
  input  logic              agentRxRd,
  output logic [DATA_W-1:0] agentRxData,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              ovrIrq,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd
);

  csx_strobe_t       strobe;
  logic              txEn, rxEn, txEmpty, rxFull, overrun;
  logic [DATA_W-1:0] txHold, rxHold;

  csx_ctrl #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regSel    (regSel),
    .regWr     (regWr),
    .wrBits    (regWdata[2:0]),
    .agentTxWr (agentTxWr),
    .agentRxRd (agentRxRd),
    .strobe    (strobe),
    .sclk      (sclk),
    .txEn      (txEn),
    .rxEn      (rxEn),
    .txEmpty   (txEmpty),
    .rxFull    (rxFull),
    .overrun   (overrun),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq),
    .ovrIrq    (ovrIrq)
  );

  csx_datapath #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cpuData   (regWdata),
    .agentData (agentTxData),
    .rxd       (rxd),
    .txd       (txd),
    .txHold    (txHold),
    .rxHold    (rxHold)
  );

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CTRL: regRdata[1:0] = {rxEn, txEn};
      SEL_STAT: begin
        regRdata[FLAG_TXE] = txEmpty;
        regRdata[FLAG_RXF] = rxFull;
        regRdata[FLAG_OVR] = overrun;
      end
      SEL_TXH:  regRdata = txHold;
      default:  regRdata = rxHold;
    endcase
  end

  assign agentRxData = rxHold;

  // R2: serial output moves only with a falling shift clock
  p_txd_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $fell(sclk));

  // R7: the byte already held is kept when overrun is raised
  p_ovr_keeps_rx_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $stable(rxHold));

endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;

  localparam int W = 8;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]   regSel = '0;
  logic         regWr = 1'b0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic         agentTxWr = 1'b0;
  logic [W-1:0] agentTxData = '0;
  logic         agentRxRd = 1'b0;
  logic [W-1:0] agentRxData;
  logic         txIrq, rxIrq, ovrIrq, sclk, txd, rxd;

  logic         loopBack = 1'b0;
  logic         patBit = 1'b0;
  logic [W-1:0] patByte = '0;
  int           patIdx = 0;
  int           fallCnt = 0;

  assign rxd = loopBack ? txd : patBit;

  always @(negedge sclk) begin
    patBit  = patByte[patIdx];
    patIdx  = (patIdx + 1) % W;
    fallCnt = fallCnt + 1;
  end

  sync_serial_xcvr #(.DATA_W(W), .DIV_HALF(H)) i_sync_serial_xcvr (
    .clk(clk), .rst(rst), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .agentTxWr(agentTxWr), .agentTxData(agentTxData),
    .agentRxRd(agentRxRd), .agentRxData(agentRxData), .txIrq(txIrq),
    .rxIrq(rxIrq), .ovrIrq(ovrIrq), .sclk(sclk), .txd(txd), .rxd(rxd)
  );

  int nCmp = 0;
  int nBad = 0;
  logic doneRun = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic         mActive, mTE, mRF, mOv, mTxEn, mRxEn, mTxOn, mRxOn;
  logic         mSclk, mTxd, pTE, pRF, pOv, mTxIrq, mRxIrq, mOvIrq;
  int           mPos;
  logic [W-1:0] mTdr, mRdr, mTxSh, mRxSh;

  always @(posedge clk) begin : model
    logic oTE, oRF, oOv, oTxEn, oRxEn, want, lastSamp, doStart;
    logic [W-1:0] oTdr;
    int k;
    if (rst) begin
      mActive = 0; mTE = 1; mRF = 0; mOv = 0; mTxEn = 0; mRxEn = 0;
      mTxOn = 0; mRxOn = 0; mSclk = 1; mTxd = 1; pTE = 1; pRF = 0; pOv = 0;
      mTxIrq = 0; mRxIrq = 0; mOvIrq = 0; mPos = 0;
      mTdr = '0; mRdr = '0; mTxSh = '0; mRxSh = '0;
    end else begin
      oTE = mTE; oRF = mRF; oOv = mOv; oTxEn = mTxEn; oRxEn = mRxEn; oTdr = mTdr;
      want = oTxEn ? !oTE : (oRxEn && !oOv);
      lastSamp = 0; doStart = 0;
      if (mActive) begin
        mPos++;
        if (mPos % H == 0) begin
          k = mPos / H;
          if (k % 2 == 1) begin
            mSclk = 1;
            if (mRxOn) mRxSh[(k-1)/2] = rxd;
            if (k == 2*W-1) lastSamp = 1;
          end else if (k < 2*W) begin
            mSclk = 0;
            if (mTxOn) mTxd = mTxSh[k/2];
          end else if (want) doStart = 1;
          else mActive = 0;
        end
      end else if (want) doStart = 1;
      if (regWr) begin
        case (regSel)
          2'd0: begin mTxEn = regWdata[0]; mRxEn = regWdata[1]; end
          2'd1: begin
            if (!regWdata[0]) mTE = 0;
            if (!regWdata[1]) mRF = 0;
            if (!regWdata[2]) mOv = 0;
          end
          2'd2: mTdr = regWdata;
          default: ;
        endcase
      end
      if (agentTxWr) begin mTdr = agentTxData; mTE = 0; end
      if (agentRxRd) mRF = 0;
      if (lastSamp && mRxOn) begin
        if (oRF) mOv = 1;
        else begin mRdr = mRxSh; mRF = 1; end
      end
      if (doStart) begin
        mActive = 1; mPos = 0; mSclk = 0;
        mTxOn = oTxEn; mRxOn = oRxEn && !oOv;
        if (oTxEn) begin mTxSh = oTdr; mTxd = oTdr[0]; mTE = 1; end
      end
      mTxIrq = mTE && !pTE; mRxIrq = mRF && !pRF; mOvIrq = mOv && !pOv;
      pTE = mTE; pRF = mRF; pOv = mOv;
    end
  end

  function automatic logic [W-1:0] mRead(input logic [1:0] sel);
    logic [W-1:0] v = '0;
    case (sel)
      2'd0: v[1:0] = {mRxEn, mTxEn};
      2'd1: v[2:0] = {mOv, mRF, mTE};
      2'd2: v = mTdr;
      default: v = mRdr;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && !doneRun) begin
      chk("R10", "sclk", sclk, mSclk);
      chk("R2", "txd", txd, mTxd);
      chk("R5", "txIrq", txIrq, mTxIrq);
      chk("R6", "rxIrq", rxIrq, mRxIrq);
      chk("R7", "ovrIrq", ovrIrq, mOvIrq);
      chk("R3", "regRdata", regRdata, mRead(regSel));
      chk("R11", "agentRxData", agentRxData, mRdr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cpuWr(input logic [1:0] sel, input logic [W-1:0] d);
    @(posedge clk); #2 regSel = sel; regWdata = d; regWr = 1'b1;
    @(posedge clk); #2 regWr = 1'b0;
  endtask

  task automatic agWr(input logic [W-1:0] d);
    @(posedge clk); #2 agentTxData = d; agentTxWr = 1'b1;
    @(posedge clk); #2 agentTxWr = 1'b0;
  endtask

  task automatic agRd();
    @(posedge clk); #2 agentRxRd = 1'b1;
    @(posedge clk); #2 agentRxRd = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [W-1:0] v);
    @(posedge clk); #2 regSel = sel; #1 v = regRdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run hung, actual cycles=150000 expected fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1 reset state
    readReg(2'd1, v); chk("R1", "status after reset", v, 8'h01);
    readReg(2'd0, v); chk("R1", "control after reset", v, 8'h00);
    chk("R1", "sclk after reset", sclk, 1'b1);
    chk("R1", "txd after reset", txd, 1'b1);

    // full duplex loopback: R4 R9 R13 R10
    loopBack = 1'b1;
    cpuWr(2'd0, 8'h00);
    cpuWr(2'd0, 8'h03);
    cpuWr(2'd2, 8'hA5);
    repeat (4) @(posedge clk); #1;
    chk("R4", "no frame before commit", sclk, 1'b1);
    readReg(2'd1, v); chk("R4", "status before commit", v, 8'h01);
    cpuWr(2'd1, 8'hFE);
    fallCnt = 0;
    agWr(8'h5A);
    repeat (35) @(posedge clk); #1;
    chk("R13", "loopback first byte", agentRxData, 8'hA5);
    agRd();
    repeat (22) @(posedge clk); #1;
    chk("R9", "falls over two frames", fallCnt, 16);
    repeat (10) @(posedge clk); #1;
    chk("R13", "loopback second byte", agentRxData, 8'h5A);
    readReg(2'd1, v); chk("R11", "status after duplex", v, 8'h03);
    repeat (5) @(posedge clk); #1;
    chk("R10", "sclk stopped", sclk, 1'b1);
    chk("R10", "txd holds last bit", txd, 1'b0);

    // receive only: R12 R7 R8
    cpuWr(2'd0, 8'h00);
    loopBack = 1'b0;
    agRd();
    patIdx = 0; patByte = 8'h3C;
    cpuWr(2'd0, 8'h02);
    repeat (36) @(posedge clk);
    readReg(2'd1, v); chk("R12", "status after first rx", v, 8'h03);
    chk("R12", "rx-only byte", agentRxData, 8'h3C);
    chk("R12", "clock still running", fallCnt > 0, 1'b1);
    patByte = 8'h99;
    repeat (40) @(posedge clk);
    readReg(2'd1, v); chk("R7", "overrun status", v, 8'h07);
    chk("R7", "held byte kept", agentRxData, 8'h3C);
    fallCnt = 0;
    repeat (20) @(posedge clk); #1;
    chk("R8", "no clock during overrun", fallCnt, 0);
    agRd();
    readReg(2'd1, v); chk("R8", "still halted after read", v, 8'h05);
    patIdx = 0;
    cpuWr(2'd1, 8'hFB);
    repeat (36) @(posedge clk);
    readReg(2'd1, v); chk("R8", "status after resume", v, 8'h03);
    chk("R8", "byte after resume", agentRxData, 8'h99);
    cpuWr(2'd0, 8'h00);
    repeat (40) @(posedge clk);

    // random phase, checked by the reference model every cycle
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) loopBack = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) patByte = W'($urandom);
      case ($urandom_range(0, 7))
        0: cpuWr(2'd0, W'($urandom_range(0, 3)));
        1: cpuWr(2'd1, W'($urandom));
        2: cpuWr(2'($urandom_range(2, 3)), W'($urandom));
        3: agWr(W'($urandom));
        4: agRd();
        default: begin
          @(posedge clk); #2 regSel = 2'($urandom_range(0, 3));
          repeat ($urandom_range(0, 20)) @(posedge clk);
        end
      endcase
    end

    repeat (5) @(posedge clk);
    doneRun = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule